// File: doc/BRIEF.md
# Quad-Tree Minimum-Cost Broadcast Switch

This switch is one node of a four-way hierarchical tree network whose only job is to spread the lowest tour cost found so far to every processing element. It has four child ports, which lead to leaf processing elements or to lower switches, and an optional parent port toward the next level up. Every port carries a record made of a path cost, a vertex list and a one-bit update flag. A flag of 1 means "update, consider this record". A flag of 0 means "no transmission".

Each cycle the switch looks at the flagged inputs and picks the one with the lowest cost. It remembers the best cost it has already forwarded. When the winner is strictly cheaper than that stored cost, the winning record is registered into all output buffers. The outputs are flagged as updates on every port except the source port, so the value is not echoed back. When nothing improves, every output flag is 0. The root instance is built without a parent port.

The record flag acts as the valid of a stream. There is no ready and no back-pressure: the switch accepts a record on every port in every cycle. Receivers must take any flagged record in the cycle it appears, because the output buffer is overwritten or its flag cleared one cycle later. In a tree of N leaves a new best cost reaches every leaf in at most 2*ceil(log4 N) switch hops.

Top module: `qts_switch`

## Requirements
- R1: After reset every output update flag is 0.
- R2: An input whose update flag is 0 takes no part in the selection, whatever its cost.
- R3: When a flagged input wins, its cost and vertex list appear on every output port one clock after the input was presented. Port k occupies bits [k*CW +: CW] of the cost bus and [k*VW +: VW] of the vertex bus.
- R4: Among flagged inputs with equal lowest cost, the lowest port index wins. Children are ports 0 to 3 and the parent is port 4.
- R5: When a record is forwarded, the output flag is 0 on the port it came from and 1 on every other port.
- R6: A flagged winner is forwarded only if its cost is strictly lower than the stored best cost, which it then replaces. Otherwise all output flags are 0 in the next cycle.
- R7: Reset sets the stored best cost to all ones, so a record whose cost is all ones is never forwarded.
- R8: With HAS_PARENT = 0 the switch has exactly four ports (indices 0 to 3), used as the tree root.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_upd | input | NP | Per-port input update flag (1 = update) |
| in_cost | input | NP*CW | Per-port input path cost |
| in_vlist | input | NP*VW | Per-port input vertex list |
| out_upd | output | NP | Per-port output update flag |
| out_cost | output | NP*CW | Per-port output path cost |
| out_vlist | output | NP*VW | Per-port output vertex list |

In this table NP = 4 + HAS_PARENT.

## Verification
The bench builds two instances with a 3-bit cost and a 4-bit vertex list: one with the parent port and one root with HAS_PARENT = 0. The narrow cost makes ties, the all-ones reset value and every flag mask across five ports frequent. The bench sweeps all 32 flag masks against sixteen cost patterns and resets before each trial, so every trial is checked against a fresh stored best. Short directed sequences then cover the stored-best suppression over several cycles, tie ordering and a cheap parent record that must not reach the root.

// File: rtl/qts_pkg.sv
package qts_pkg;
  localparam int CHILD_PORTS = 4;

  function automatic int port_count(input int has_parent);
    return CHILD_PORTS + ((has_parent != 0) ? 1 : 0);
  endfunction
endpackage

// File: rtl/qts_min_select.sv
module qts_min_select #(
  parameter int NP = 5,
  parameter int CW = 8,
  parameter int VW = 16,
  parameter int IW = 3
) (
  input  logic [NP-1:0]    in_upd,
  input  logic [NP*CW-1:0] in_cost,
  input  logic [NP*VW-1:0] in_vlist,
  output logic             win_valid,
  output logic [IW-1:0]    win_idx,
  output logic [CW-1:0]    win_cost,
  output logic [VW-1:0]    win_vlist
);
  logic [NP:0]         st_v;
  logic [NP:0][CW-1:0] st_c;
  logic [NP:0][VW-1:0] st_l;
  logic [NP:0][IW-1:0] st_i;

  assign st_v[0] = 1'b0;
  assign st_c[0] = '1;
  assign st_l[0] = '0;
  assign st_i[0] = '0;

  for (genvar p = 0; p < NP; p++) begin : g_stage
    logic [CW-1:0] c_p;
    logic          take;
    assign c_p  = in_cost[p*CW +: CW];
    // strict compare keeps the earlier (lower) index on a tie
    assign take = in_upd[p] && (!st_v[p] || (c_p < st_c[p]));
    assign st_v[p+1] = st_v[p] | in_upd[p];
    assign st_c[p+1] = take ? c_p : st_c[p];
    assign st_l[p+1] = take ? in_vlist[p*VW +: VW] : st_l[p];
    assign st_i[p+1] = take ? IW'(p) : st_i[p];
  end

  assign win_valid = st_v[NP];
  assign win_cost  = st_c[NP];
  assign win_vlist = st_l[NP];
  assign win_idx   = st_i[NP];

  always_comb begin
    if (win_valid) begin
      a_winner_flagged_r2: assert (in_upd[win_idx]);
    end
  end
endmodule

// File: rtl/qts_best.sv
module qts_best #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          win_valid,
  input  logic [CW-1:0] win_cost,
  output logic          improve
);
  logic [CW-1:0] best_q;

  assign improve = win_valid && (win_cost < best_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) best_q <= '1;
    else if (improve) best_q <= win_cost;
  end

  p_best_never_rises_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (best_q <= $past(best_q)));
  p_improve_lowers_r6: assert property (@(posedge clk) disable iff (!rst_n)
    improve |=> (best_q < $past(best_q)));
  p_ones_never_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (win_cost == '1) |-> !improve);
endmodule

// File: rtl/qts_fanout.sv
module qts_fanout #(
  parameter int NP = 5,
  parameter int CW = 8,
  parameter int VW = 16,
  parameter int IW = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             improve,
  input  logic [IW-1:0]    win_idx,
  input  logic [CW-1:0]    win_cost,
  input  logic [VW-1:0]    win_vlist,
  output logic [NP-1:0]    out_upd,
  output logic [NP*CW-1:0] out_cost,
  output logic [NP*VW-1:0] out_vlist
);
  for (genvar k = 0; k < NP; k++) begin : g_port
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        out_upd[k]            <= 1'b0;
        out_cost[k*CW +: CW]  <= '1;
        out_vlist[k*VW +: VW] <= '0;
      end else begin
        out_upd[k] <= improve && (win_idx != IW'(k));
        if (improve) begin
          out_cost[k*CW +: CW]  <= win_cost;
          out_vlist[k*VW +: VW] <= win_vlist;
        end
      end
    end
  end

  p_echo_suppressed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|out_upd) |-> ($countones(out_upd) == NP - 1));
  p_source_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    improve |=> !out_upd[$past(win_idx)]);
endmodule

// File: rtl/qts_switch.sv
module qts_switch #(
  parameter int HAS_PARENT = 1,
  parameter int CW         = 8,
  parameter int VW         = 16
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [qts_pkg::port_count(HAS_PARENT)-1:0]    in_upd,
  input  logic [qts_pkg::port_count(HAS_PARENT)*CW-1:0] in_cost,
  input  logic [qts_pkg::port_count(HAS_PARENT)*VW-1:0] in_vlist,
  output logic [qts_pkg::port_count(HAS_PARENT)-1:0]    out_upd,
  output logic [qts_pkg::port_count(HAS_PARENT)*CW-1:0] out_cost,
  output logic [qts_pkg::port_count(HAS_PARENT)*VW-1:0] out_vlist
);
  localparam int NP = qts_pkg::port_count(HAS_PARENT);
  localparam int IW = $clog2(NP);

  logic          win_valid;
  logic [IW-1:0] win_idx;
  logic [CW-1:0] win_cost;
  logic [VW-1:0] win_vlist;
  logic          improve;

  qts_min_select #(.NP(NP), .CW(CW), .VW(VW), .IW(IW)) u_sel (
    .in_upd(in_upd), .in_cost(in_cost), .in_vlist(in_vlist),
    .win_valid(win_valid), .win_idx(win_idx),
    .win_cost(win_cost), .win_vlist(win_vlist)
  );

  qts_best #(.CW(CW)) u_best (
    .clk(clk), .rst_n(rst_n),
    .win_valid(win_valid), .win_cost(win_cost), .improve(improve)
  );

  qts_fanout #(.NP(NP), .CW(CW), .VW(VW), .IW(IW)) u_fan (
    .clk(clk), .rst_n(rst_n), .improve(improve),
    .win_idx(win_idx), .win_cost(win_cost), .win_vlist(win_vlist),
    .out_upd(out_upd), .out_cost(out_cost), .out_vlist(out_vlist)
  );

  p_needs_flagged_input_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|out_upd) |-> $past(|in_upd));
  p_port_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $bits(out_upd) == 4 + HAS_PARENT);

  for (genvar k = 1; k < NP; k++) begin : g_same
    p_same_record_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (|out_upd) |-> (out_cost[k*CW +: CW] == out_cost[CW-1:0]
                      && out_vlist[k*VW +: VW] == out_vlist[VW-1:0]));
  end
endmodule

// File: tb/qts_switch_test.sv
module qts_switch_test;
  localparam int CW = 3;
  localparam int VW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [4:0]     p_in_upd = '0;
  logic [5*CW-1:0] p_in_cost = '0;
  logic [5*VW-1:0] p_in_vl = '0;
  logic [4:0]     p_out_upd;
  logic [5*CW-1:0] p_out_cost;
  logic [5*VW-1:0] p_out_vl;
  logic [3:0]     r_out_upd;
  logic [4*CW-1:0] r_out_cost;
  logic [4*VW-1:0] r_out_vl;

  qts_switch #(.HAS_PARENT(1), .CW(CW), .VW(VW)) uut (
    .clk(clk), .rst_n(rst_n), .in_upd(p_in_upd), .in_cost(p_in_cost),
    .in_vlist(p_in_vl), .out_upd(p_out_upd), .out_cost(p_out_cost),
    .out_vlist(p_out_vl));

  qts_switch #(.HAS_PARENT(0), .CW(CW), .VW(VW)) uut_root (
    .clk(clk), .rst_n(rst_n), .in_upd(p_in_upd[3:0]), .in_cost(p_in_cost[4*CW-1:0]),
    .in_vlist(p_in_vl[4*VW-1:0]), .out_upd(r_out_upd), .out_cost(r_out_cost),
    .out_vlist(r_out_vl));

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int best_p, best_r;
  int cst[5];
  int vls[5];

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int pick(input int np, input logic [4:0] m);
    int w = -1;
    for (int i = 0; i < np; i++)
      if (m[i] && (w < 0 || cst[i] < cst[w])) w = i;
    return w;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    p_in_upd = '0;
    @(negedge clk);
    rst_n = 1'b1;
    best_p = (1 << CW) - 1;
    best_r = (1 << CW) - 1;
  endtask

  // present one set of records, check both instances one clock later
  task automatic trial(input logic [4:0] m, input string req);
    int wp, wr, fp, fr;
    wp = pick(5, m);
    wr = pick(4, m);
    if (wp >= 0 && cst[wp] >= best_p) wp = -1;
    if (wr >= 0 && cst[wr] >= best_r) wr = -1;
    if (wp >= 0) best_p = cst[wp];
    if (wr >= 0) best_r = cst[wr];
    fp = (wp < 0) ? 0 : (5'h1f & ~(5'd1 << wp));
    fr = (wr < 0) ? 0 : (4'hf & ~(4'd1 << wr));
    p_in_upd = m;
    for (int i = 0; i < 5; i++) begin
      p_in_cost[i*CW +: CW] = CW'(cst[i]);
      p_in_vl[i*VW +: VW] = VW'(vls[i]);
    end
    @(negedge clk);
    p_in_upd = '0;
    chk({req, " R5 flags"}, int'(p_out_upd), fp);
    chk({req, " R8 root flags"}, int'(r_out_upd), fr);
    if (wp >= 0)
      for (int k = 0; k < 5; k++) begin
        chk({req, " R3 cost"}, int'(p_out_cost[k*CW +: CW]), cst[wp]);
        chk({req, " R3 vlist"}, int'(p_out_vl[k*VW +: VW]), vls[wp]);
      end
    if (wr >= 0)
      for (int k = 0; k < 4; k++) begin
        chk({req, " R8 root cost"}, int'(r_out_cost[k*CW +: CW]), cst[wr]);
        chk({req, " R8 root vlist"}, int'(r_out_vl[k*VW +: VW]), vls[wr]);
      end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    best_p = 7; best_r = 7;
    // R1: flags clear after reset
    chk("R1 reset flags", int'(p_out_upd), 0);
    chk("R1 reset root flags", int'(r_out_upd), 0);

    // sweep: every flag mask against sixteen cost patterns (R2 R3 R4 R5 R6 R7)
    for (int m = 0; m < 32; m++)
      for (int s = 0; s < 16; s++) begin
        do_reset();
        for (int i = 0; i < 5; i++) begin
          cst[i] = (m * 3 + s * 5 + i * 7 + i * s) % 8;
          vls[i] = (i * 3 + s + m) % 16;
        end
        trial(5'(m), "R2 sweep");
      end

    // R6: stored best suppresses repeats and worse costs
    do_reset();
    for (int i = 0; i < 5; i++) begin cst[i] = 5; vls[i] = i + 1; end
    trial(5'b00100, "R6 first");
    trial(5'b00100, "R6 repeat");
    trial(5'b00010, "R6 equal other port");
    cst[0] = 3;
    trial(5'b00001, "R6 lower");
    cst[3] = 4;
    trial(5'b01000, "R6 higher");
    chk("R6 stored best", best_p, 3);

    // R7: all-ones cost never forwarded
    do_reset();
    for (int i = 0; i < 5; i++) begin cst[i] = 7; vls[i] = 9; end
    trial(5'b11111, "R7 all ones");

    // R4: tie between ports 1 and 3 and parent
    do_reset();
    for (int i = 0; i < 5; i++) begin cst[i] = 6; vls[i] = i + 10; end
    cst[1] = 2; cst[3] = 2; cst[4] = 2;
    trial(5'b11010, "R4 tie");

    // R8: cheap parent record reaches parent-capable switch only
    do_reset();
    for (int i = 0; i < 5; i++) begin cst[i] = 5; vls[i] = i; end
    cst[4] = 0;
    trial(5'b10001, "R8 parent cheap");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule